// File: doc/BRIEF.md
# Pixel Rectangle Copy Engine

This block moves a rectangle of 16-bit pixels from one place to another inside a 1024 x 512 pixel image memory. A controller gives it three 32-bit words, the source corner, the destination corner and the rectangle size, together with a flag that forces the top pixel bit on every written pixel. It pulses `start`. The engine then drives a single-port synchronous memory interface until every row has been moved, and it signals completion with a one-cycle `done`.

Coordinates wrap at the image edges: columns wrap modulo 1024 and rows wrap modulo 512. When the destination begins inside the source span of the same row, or when either span crosses the right edge, or when the top-bit flag is set, the engine copies each row in pieces of up to 32 pixels. It reads each piece into a small line buffer before it writes any of it. Otherwise it moves one pixel at a time, reading the pixel and then writing it. A copy onto itself with the flag clear finishes at once and does not touch memory.

Top module: `vram_blit`

## Requirements
- R1: The source and destination X are taken from bits 9:0 of their words, and Y from bits 24:16. All other bits of these words are ignored. The memory address of pixel (x, y) is y*1024 + x.
- R2: Width is ((bits 9:0 of the size word - 1) mod 1024) + 1, and height is ((bits 24:16 - 1) mod 512) + 1. A zero field therefore means 1024 columns or 512 rows.
- R3: When the source corner equals the destination corner and `mask_set` is 0, `done` is high in the cycle after the accepted `start`, `busy` stays low, and `mem_req` is never asserted.
- R4: Source and destination column indices wrap modulo 1024, and row indices wrap modulo 512.
- R5: When `mask_set` is 1, every written pixel has bit 15 set and bits 14:0 equal to the source pixel. This holds even when source equals destination.
- R6: In chunked mode, each row is split into pieces of 32 pixels with a shorter final piece. All reads of a piece complete before its first write, and no write follows a read in the next cycle.
- R7: In direct mode, used when none of the chunked conditions holds, each pixel is read and then written in increasing X order before the next pixel is read.
- R8: Rows are processed in increasing Y order, from row offset 0 to height-1.
- R9: `busy` is high from the cycle after an accepted `start` through the cycle of the last write. `done` is high for exactly the following cycle. A `start` that arrives while busy is ignored.
- R10: After reset, `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a copy; sampled only while idle |
| src_word | input | 32 | Source corner: X in 9:0, Y in 24:16 |
| dst_word | input | 32 | Destination corner: X in 9:0, Y in 24:16 |
| size_word | input | 32 | Width code in 9:0, height code in 24:16 |
| mask_set | input | 1 | Force bit 15 on every written pixel |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 19 | Pixel address, row*1024 + column |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |

## Verification
The assertions check the handshake on every cycle. They cover the single-cycle `done` that never overlaps `busy`, the absence of memory traffic while idle and on a self-copy, and the gap between the last read of a piece and its first write. They also check that the row counter only steps forward by one. Only the bench scenarios can show that the pixels land in the right places. They compare the whole memory image against a model after wrapped, overlapping, smeared, masked and full-width copies, and they confirm that a start raised mid-copy leaves the result unchanged.

// File: rtl/vb_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding for the rectangle copy engine.
package vb_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RD,
        S_DRAIN,
        S_WR,
        S_DONE
    } vb_state_e;
endpackage

// File: rtl/vb_decode.sv
`timescale 1ns/1ps
// vb_decode: unpacks the three command words into coordinates and a size.
// It also classifies the copy as chunked (safe) or direct, and flags a self-copy.
// Assumes: purely combinational, and evaluated in the cycle start is sampled.
module vb_decode #(
    parameter int XW   = 10,
    parameter int YW   = 9,
    parameter int YOFF = 16
) (
    input  logic [31:0]   src_word,
    input  logic [31:0]   dst_word,
    input  logic [31:0]   size_word,
    input  logic          mask_set,
    output logic [XW-1:0] sx,
    output logic [YW-1:0] sy,
    output logic [XW-1:0] dx,
    output logic [YW-1:0] dy,
    output logic [XW:0]   w,
    output logic [YW:0]   h,
    output logic          safe,
    output logic          noop
);
    localparam int EW = XW + 2;

    logic [XW-1:0] wm1;
    logic [YW-1:0] hm1;
    logic [EW-1:0] s_end, d_end;
    logic          unused_bits;

    // Field extraction and minus-one size decoding
    always_comb begin
        sx  = src_word[XW-1:0];
        sy  = src_word[YOFF+YW-1:YOFF];
        dx  = dst_word[XW-1:0];
        dy  = dst_word[YOFF+YW-1:YOFF];
        wm1 = size_word[XW-1:0] - 1'b1;
        hm1 = size_word[YOFF+YW-1:YOFF] - 1'b1;
        w   = {1'b0, wm1} + 1'b1;
        h   = {1'b0, hm1} + 1'b1;
    end

    // Path choice: overlap to the right, edge crossing, or mask forces chunking
    always_comb begin
        s_end = EW'(sx) + EW'(w);
        d_end = EW'(dx) + EW'(w);
        safe  = ((sx < dx) && (EW'(dx) < s_end))
              || (s_end > EW'(2**XW))
              || (d_end > EW'(2**XW))
              || mask_set;
        noop  = (sx == dx) && (sy == dy) && !mask_set;
    end

    assign unused_bits = ^{src_word[31:YOFF+YW], src_word[YOFF-1:XW],
                           dst_word[31:YOFF+YW], dst_word[YOFF-1:XW],
                           size_word[31:YOFF+YW], size_word[YOFF-1:XW]};
endmodule

// File: rtl/vb_linebuf.sv
`timescale 1ns/1ps
// vb_linebuf: small pixel store holding one chunk of a row.
// Assumes: one synchronous write port and one combinational read port, no reset on contents.
module vb_linebuf #(
    parameter int DEPTH = 32,
    parameter int DW    = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] store [DEPTH];

    // Capture a returning read pixel into its slot
    always_ff @(posedge clk) begin
        if (wr_en) store[wr_idx] <= wr_data;
    end

    // Present the slot being written back to memory
    assign rd_data = store[rd_idx];
endmodule

// File: rtl/vb_seq.sv
`timescale 1ns/1ps
// vb_seq: row/chunk sequencer. Per chunk it issues all reads, waits one drain
// cycle for the last read data, then issues all writes, and steps rows upward.
// Assumes: memory returns read data the cycle after the request.
module vb_seq
    import vb_pkg::*;
#(
    parameter int XW    = 10,
    parameter int YW    = 9,
    parameter int DEPTH = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int AW   = XW + YW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [XW-1:0] sx_in,
    input  logic [YW-1:0] sy_in,
    input  logic [XW-1:0] dx_in,
    input  logic [YW-1:0] dy_in,
    input  logic [XW:0]   w_in,
    input  logic [YW:0]   h_in,
    input  logic          safe_in,
    input  logic          noop_in,
    input  logic          mask_in,
    output logic          busy,
    output logic          done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic          cap_en,
    output logic [IW-1:0] cap_idx,
    output logic [IW-1:0] buf_idx,
    output logic          mask_q
);
    vb_state_e     state;
    logic [XW-1:0] sx_q, dx_q;
    logic [YW-1:0] sy_q, dy_q;
    logic [XW:0]   w_q, xoff, xoff_nx;
    logic [YW:0]   h_q, row;
    logic          safe_q;
    logic [IW-1:0] idx;
    logic [IW:0]   n;
    logic          idx_last;
    logic [XW-1:0] rd_x, wr_x;
    logic [YW-1:0] rd_y, wr_y;

    // Length of the next piece: one pixel in direct mode, up to DEPTH when chunked
    function automatic logic [IW:0] chunk_len(input logic [XW:0] rem, input logic chunked);
        if (!chunked)                   return (IW+1)'(1);
        else if (rem >= (XW+1)'(DEPTH)) return (IW+1)'(DEPTH);
        else                            return rem[IW:0];
    endfunction

    // Position bookkeeping within the current piece and row
    always_comb begin
        idx_last = ((IW+1)'(idx) == (n - (IW+1)'(1)));
        xoff_nx  = xoff + (XW+1)'(n);
        rd_x     = sx_q + xoff[XW-1:0] + XW'(idx);
        wr_x     = dx_q + xoff[XW-1:0] + XW'(idx);
        rd_y     = sy_q + row[YW-1:0];
        wr_y     = dy_q + row[YW-1:0];
    end

    // Memory interface and status decoded from the state register
    always_comb begin
        busy     = (state == S_RD) || (state == S_DRAIN) || (state == S_WR);
        done     = (state == S_DONE);
        mem_req  = (state == S_RD) || (state == S_WR);
        mem_we   = (state == S_WR);
        mem_addr = (state == S_WR) ? {wr_y, wr_x} : {rd_y, rd_x};
        buf_idx  = idx;
    end

    // Main sequencer: accept, read piece, drain, write piece, advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            sx_q    <= '0;
            sy_q    <= '0;
            dx_q    <= '0;
            dy_q    <= '0;
            w_q     <= '0;
            h_q     <= '0;
            safe_q  <= 1'b0;
            mask_q  <= 1'b0;
            row     <= '0;
            xoff    <= '0;
            idx     <= '0;
            n       <= '0;
            cap_en  <= 1'b0;
            cap_idx <= '0;
        end else begin
            cap_en  <= (state == S_RD);
            cap_idx <= idx;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        sx_q   <= sx_in;
                        sy_q   <= sy_in;
                        dx_q   <= dx_in;
                        dy_q   <= dy_in;
                        w_q    <= w_in;
                        h_q    <= h_in;
                        safe_q <= safe_in;
                        mask_q <= mask_in;
                        row    <= '0;
                        xoff   <= '0;
                        idx    <= '0;
                        n      <= chunk_len(w_in, safe_in);
                        state  <= noop_in ? S_DONE : S_RD;
                    end
                end
                S_RD: begin
                    if (idx_last) begin
                        idx   <= '0;
                        state <= S_DRAIN;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_DRAIN: state <= S_WR;
                S_WR: begin
                    if (!idx_last) begin
                        idx <= idx + 1'b1;
                    end else begin
                        idx <= '0;
                        if (xoff_nx == w_q) begin
                            xoff <= '0;
                            n    <= chunk_len(w_q, safe_q);
                            if (row == h_q - 1'b1) begin
                                state <= S_DONE;
                            end else begin
                                row   <= row + 1'b1;
                                state <= S_RD;
                            end
                        end else begin
                            xoff  <= xoff_nx;
                            n     <= chunk_len(w_q - xoff_nx, safe_q);
                            state <= S_RD;
                        end
                    end
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: busy and done never overlap
    a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R10: no memory traffic outside a copy
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R3: a self-copy without mask completes next cycle with no access
    a_r3_noop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && noop_in) |=> (done && !mem_req));

    // R6: the last read of a piece is never followed directly by a write
    a_r6_drain_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !(mem_req && mem_we));

    // R8: rows only advance by one during a copy
    a_r8_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && !$stable(row)) |-> (row == $past(row) + 1'b1));
endmodule

// File: rtl/vram_blit.sv
`timescale 1ns/1ps
// vram_blit: rectangle copy engine for a 1024x512 16-bit pixel memory.
// Decodes the command words, sequences reads and writes through a
// single-port synchronous memory, and buffers each chunk in a line buffer.
// Assumes: read data is valid one cycle after a read request.
module vram_blit #(
    parameter int XW    = 10,
    parameter int YW    = 9,
    parameter int PW    = 16,
    parameter int DEPTH = 32,
    localparam int AW   = XW + YW,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [31:0]   src_word,
    input  logic [31:0]   dst_word,
    input  logic [31:0]   size_word,
    input  logic          mask_set,
    output logic          busy,
    output logic          done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [PW-1:0] mem_wdata,
    input  logic [PW-1:0] mem_rdata
);
    logic [XW-1:0] sx, dx;
    logic [YW-1:0] sy, dy;
    logic [XW:0]   w;
    logic [YW:0]   h;
    logic          safe, noop;
    logic          cap_en, mask_q;
    logic [IW-1:0] cap_idx, buf_idx;
    logic [PW-1:0] buf_data;

    vb_decode #(.XW(XW), .YW(YW)) u_dec (
        .src_word (src_word),
        .dst_word (dst_word),
        .size_word(size_word),
        .mask_set (mask_set),
        .sx       (sx),
        .sy       (sy),
        .dx       (dx),
        .dy       (dy),
        .w        (w),
        .h        (h),
        .safe     (safe),
        .noop     (noop)
    );

    vb_seq #(.XW(XW), .YW(YW), .DEPTH(DEPTH)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .sx_in   (sx),
        .sy_in   (sy),
        .dx_in   (dx),
        .dy_in   (dy),
        .w_in    (w),
        .h_in    (h),
        .safe_in (safe),
        .noop_in (noop),
        .mask_in (mask_set),
        .busy    (busy),
        .done    (done),
        .mem_req (mem_req),
        .mem_we  (mem_we),
        .mem_addr(mem_addr),
        .cap_en  (cap_en),
        .cap_idx (cap_idx),
        .buf_idx (buf_idx),
        .mask_q  (mask_q)
    );

    vb_linebuf #(.DEPTH(DEPTH), .DW(PW)) u_buf (
        .clk    (clk),
        .wr_en  (cap_en),
        .wr_idx (cap_idx),
        .wr_data(mem_rdata),
        .rd_idx (buf_idx),
        .rd_data(buf_data)
    );

    // Write data: buffered pixel with the top bit forced when masking
    assign mem_wdata = buf_data | {mask_q, {(PW-1){1'b0}}};
endmodule

// File: tb/sim_vram_blit.sv
`timescale 1ns/1ps
module sim_vram_blit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src_word = '0, dst_word = '0, size_word = '0;
    logic        mask_set = 1'b0;
    logic        busy, done, mem_req, mem_we;
    logic [18:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    int nchk = 0;
    int nbad = 0;

    logic [15:0] vmem [int];
    logic [15:0] refm [int];

    always #2 clk = ~clk;

    vram_blit u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_word(src_word), .dst_word(dst_word), .size_word(size_word),
        .mask_set(mask_set), .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] pix_init(int a);
        return 16'(((a * 37) + ((a >> 5) * 11) + 7) & 32'h7fff);
    endfunction

    function automatic logic [15:0] vrd(int a);
        return vmem.exists(a) ? vmem[a] : pix_init(a);
    endfunction

    function automatic logic [15:0] rrd(int a);
        return refm.exists(a) ? refm[a] : pix_init(a);
    endfunction

    // Single-port synchronous memory, one-cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) vmem[int'(mem_addr)] = mem_wdata;
            else        mem_rdata <= vrd(int'(mem_addr));
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Requirement model of one copy
    task automatic model_copy(input logic [31:0] s, input logic [31:0] d,
                              input logic [31:0] z, input bit m);
        int sx, sy, dx, dy, w, h, n;
        bit safe;
        logic [15:0] lb [32];
        sx = int'(s[9:0]);  sy = int'(s[24:16]);
        dx = int'(d[9:0]);  dy = int'(d[24:16]);
        w  = ((int'(z[9:0]) - 1) & 1023) + 1;
        h  = ((int'(z[24:16]) - 1) & 511) + 1;
        if (sx == dx && sy == dy && !m) return;
        safe = (sx < dx && dx < sx + w) || (sx + w > 1024) || (dx + w > 1024) || m;
        for (int r = 0; r < h; r++) begin
            int ys = ((sy + r) & 511) * 1024;
            int yd = ((dy + r) & 511) * 1024;
            if (safe) begin
                for (int x0 = 0; x0 < w; x0 += 32) begin
                    n = (w - x0 > 32) ? 32 : w - x0;
                    for (int j = 0; j < n; j++) lb[j] = rrd(ys + ((sx + x0 + j) & 1023));
                    for (int j = 0; j < n; j++)
                        refm[yd + ((dx + x0 + j) & 1023)] = lb[j] | (m ? 16'h8000 : 16'h0);
                end
            end else begin
                for (int j = 0; j < w; j++)
                    refm[yd + ((dx + j) & 1023)] = rrd(ys + ((sx + j) & 1023));
            end
        end
    endtask

    task automatic compare_img(input string req);
        int bad = 0;
        foreach (refm[k]) if (!vmem.exists(k) || vmem[k] != refm[k]) bad++;
        foreach (vmem[k]) if (!refm.exists(k)) bad++;
        check(bad == 0, req, "memory image mismatching pixels", bad, 0);
    endtask

    // Issue one copy, follow it to done, check timing and the final image
    task automatic run_copy(input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] z, input bit m, input string req,
                            input bit is_noop, input bit inject);
        int cyc, last_we, reqs;
        @(negedge clk);
        src_word = s; dst_word = d; size_word = z; mask_set = m; start = 1'b1;
        @(posedge clk); #1;
        if (is_noop) check(done && !busy, "R3", "done next cycle", int'(done), 1);
        else         check(busy, "R9", "busy after start", int'(busy), 1);
        @(negedge clk);
        start = 1'b0;
        cyc = 1; last_we = 0; reqs = 0;
        forever begin
            if (mem_req) reqs++;
            if (mem_req && mem_we) last_we = cyc;
            if (inject && cyc == 4) begin
                start = 1'b1; src_word = 32'h0010_0200; dst_word = 32'h0020_0300;
                size_word = 32'h0004_0004; mask_set = 1'b1;
            end
            if (inject && cyc == 5) start = 1'b0;
            if (done || cyc > 60000) break;
            @(negedge clk);
            cyc++;
        end
        if (is_noop) begin
            check(cyc == 1, "R3", "done cycle", cyc, 1);
            check(reqs == 0, "R3", "memory requests", reqs, 0);
        end else begin
            check(cyc == last_we + 1, "R9", "done cycle after last write", cyc, last_we + 1);
        end
        @(negedge clk);
        check(!done && !busy, "R9", "done single pulse", int'(done), 0);
        if (inject) begin
            reqs = 0;
            for (int i = 0; i < 6; i++) begin
                if (busy || mem_req) reqs++;
                @(negedge clk);
            end
            check(reqs == 0, "R9", "activity after ignored start", reqs, 0);
        end
        model_copy(s, d, z, m);
        compare_img(req);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req, "R10", "outputs in reset",
              int'({busy, done, mem_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_req, "R10", "outputs after reset",
              int'({busy, done, mem_req}), 0);
    endtask

    // R1 R7: plain direct copy, junk in unused word bits
    task automatic t_basic;
        run_copy(32'hFE05_FC0A, 32'h8028_412C, 32'h0003_0014, 1'b0, "R1", 1'b0, 1'b0);
    endtask

    // R3: self-copy without mask
    task automatic t_noop;
        run_copy(32'h0007_0033, 32'h0007_0033, 32'h0005_0005, 1'b0, "R3", 1'b1, 1'b0);
    endtask

    // R5: self-copy with mask still rewrites every pixel
    task automatic t_mask_same;
        run_copy(32'h0030_0040, 32'h0030_0040, 32'h0002_0006, 1'b1, "R5", 1'b0, 1'b0);
    endtask

    // R6: rightward overlap in the same rows, chunked
    task automatic t_overlap_right;
        run_copy(32'h0064_0064, 32'h0064_0069, 32'h0002_0032, 1'b0, "R6", 1'b0, 1'b0);
    endtask

    // R7: leftward overlap in the same row, direct
    task automatic t_overlap_left;
        run_copy(32'h0070_0064, 32'h0070_0062, 32'h0001_0028, 1'b0, "R7", 1'b0, 1'b0);
    endtask

    // R4: column and row wrap
    task automatic t_wrap;
        run_copy(32'h01FE_03F2, 32'h00C8_0014, 32'h0004_001E, 1'b0, "R4", 1'b0, 1'b0);
    endtask

    // R8: one-row-down overlap smears the first row downward
    task automatic t_rows;
        run_copy(32'h000A_0032, 32'h000B_0032, 32'h0005_0008, 1'b0, "R8", 1'b0, 1'b0);
    endtask

    // R2: zero width field means 1024, zero height field means 512
    task automatic t_size;
        run_copy(32'h012C_0000, 32'h012D_0000, 32'h0001_0000, 1'b0, "R2", 1'b0, 1'b0);
        run_copy(32'h0000_0005, 32'h0000_02BC, 32'h0000_0001, 1'b0, "R2", 1'b0, 1'b0);
    endtask

    // R9: start while busy is ignored
    task automatic t_busy_start;
        run_copy(32'h0050_0010, 32'h0090_0180, 32'h0003_0010, 1'b0, "R9", 1'b0, 1'b1);
    endtask

    // R5 R6: masked copy with a short final piece (32+32+6)
    task automatic t_mask_chunks;
        run_copy(32'h0100_0020, 32'h0140_0200, 32'h0002_0046, 1'b1, "R5", 1'b0, 1'b0);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_noop();
        t_mask_same();
        t_overlap_right();
        t_overlap_left();
        t_wrap();
        t_rows();
        t_size();
        t_busy_start();
        t_mask_chunks();
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nbad++;
        $display("FAIL R9 watchdog: actual still running, expected finished");
        summary();
        $finish;
    end
endmodule